// File: doc/BRIEF.md
# Time-of-Day Counter with Update Cycle

This block keeps calendar time for a system: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A reference tick of 32.768 kHz, or any rate set by a parameter, feeds a prescaler. Once per second the prescaler starts an update window. A status flag goes high a fixed number of reference ticks before the time fields change. The flag stays high for a further fixed number of ticks after the change, so software that sees it low knows it has a stable time.

Software reaches everything through a byte-wide register port with 16 addresses. Time values are held internally in binary and in 24-hour form. They are converted on every read and every write, using the coding chosen in the control register: binary or BCD, and 12-hour or 24-hour. A freeze bit stops all advancing so that software can load a new time. At the end of each update the block raises an update-ended event. It also raises an alarm event when the time matches the alarm registers. Either event can drive the interrupt line when enabled.

Top module: `tod_clock`

## Requirements
- R1: Register addresses are fixed as follows.
  - 0 is seconds, 1 is seconds alarm, 2 is minutes, 3 is minutes alarm, 4 is hours, 5 is hours alarm.
  - 6 is day of week (1 to 7), 7 is day of month, 8 is month, 9 is year (0 to 99).
  - 10 is status, with bit 7 showing update in progress and all other bits reading 0.
  - 11 is control, and reads back exactly the byte written.
  - 12 is flags. Every other address reads 0.
  - A write to addresses 0 to 9 loads that field, and a read returns it in the current coding.
- R2: After each TICKS_PER_SEC reference ticks, time advances by one second. Seconds carry into minutes, minutes into hours (0 to 23), and hours into day of month and day of week. Day of week wraps from 7 to 1. Month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0.
- R3: `uip` rises LEAD_TICKS reference ticks before the time fields change. It falls BUSY_TICKS reference ticks after they change.
- R4: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is a multiple of 4, and 28 days otherwise. All other months have 31 days.
- R5: Control bit 7 freezes the counter. While it is set, time does not advance, `uip` is low and reference ticks are discarded. The first advance after the bit clears comes a full TICKS_PER_SEC ticks later.
- R6: Control bit 2 selects the coding of all time and alarm fields, on both reads and writes. A value of 1 selects binary and 0 selects BCD.
- R7: Control bit 1 selects 24-hour coding when set. When it is clear, the hours run 12, 1, ..., 11. Hours bit 7 marks PM and toggles at the rollover from 11 to 12.
- R8: At the end of each update window, flag bit 4 (update ended) is set. Flag bit 5 (alarm) is set when seconds, minutes and hours all equal their alarm registers at that moment.
- R9: `irq` equals (alarm flag AND control bit 5) OR (update flag AND control bit 4). Flag bit 7 reads the same value as `irq`.
- R10: A read of address 12 with `rd_en` high clears both flags. If an event arrives in the same cycle, the event wins. Writes to addresses 10 and 12 have no effect.
- R11: After reset the state is as follows.
  - The time is 00:00:00 and the day of week is 1.
  - The date is day 1 of month 1 in year 0.
  - The alarms are 0, control is 0x02 (BCD, 24-hour), the flags are clear and `uip` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at the reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data in current coding |
| rd_en | input | 1 | Read strobe (clears flags when reading address 12) |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data in current coding |
| uip | output | 1 | Update in progress |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. `uip` only falls at the end of an update or on freeze, and it is low in the cycle after a freeze. An advance happens only inside the update window. The time holds still when there is neither an advance nor a write, and seconds step by exactly one. The update flag follows every update end, and the alarm flag rises only at an update end. Other behaviour needs the bench's scenarios to show it:
- carries through minute, hour, day, month and year;
- February lengths in leap and non-leap years;
- the ticks discarded under freeze;
- conversion between codings, and the 12-hour PM rollover;
- alarm matching and read-clear.

The bench's cycle-by-cycle model compares `uip`, `irq` and the addressed register on every clock.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_BUSY
    } phase_t;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [6:0] dow;
        logic [6:0] dom;
        logic [6:0] mon;
        logic [6:0] year;
    } tod_time_t;

    localparam int NFIELD = 7;

    // register addresses
    localparam logic [3:0] A_SEC   = 4'd0;
    localparam logic [3:0] A_ASEC  = 4'd1;
    localparam logic [3:0] A_MIN   = 4'd2;
    localparam logic [3:0] A_AMIN  = 4'd3;
    localparam logic [3:0] A_HOUR  = 4'd4;
    localparam logic [3:0] A_AHOUR = 4'd5;
    localparam logic [3:0] A_DOW   = 4'd6;
    localparam logic [3:0] A_DOM   = 4'd7;
    localparam logic [3:0] A_MON   = 4'd8;
    localparam logic [3:0] A_YEAR  = 4'd9;
    localparam logic [3:0] A_STAT  = 4'd10;
    localparam logic [3:0] A_CTRL  = 4'd11;
    localparam logic [3:0] A_FLAG  = 4'd12;

    // control bit positions
    localparam int C_FREEZE = 7;
    localparam int C_AEN    = 5;
    localparam int C_UEN    = 4;
    localparam int C_BIN    = 2;
    localparam int C_H24    = 1;

    function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return bin ? {1'b0, v} : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] dec_field(input logic [7:0] b, input logic bin);
        logic [6:0] r;
        r = 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
        return bin ? b[6:0] : r;
    endfunction

    function automatic logic [7:0] enc_hour(input logic [6:0] h, input logic bin, input logic h24);
        logic       pm;
        logic [6:0] h12;
        logic [7:0] e;
        pm  = (h >= 7'd12);
        h12 = pm ? h - 7'd12 : h;
        if (h12 == 7'd0) h12 = 7'd12;
        e = enc_field(h12, bin);
        return h24 ? enc_field(h, bin) : {pm, e[6:0]};
    endfunction

    function automatic logic [6:0] dec_hour(input logic [7:0] b, input logic bin, input logic h24);
        logic [6:0] h12;
        logic [6:0] h;
        h12 = dec_field({1'b0, b[6:0]}, bin);
        h   = (h12 == 7'd12) ? 7'd0 : h12;
        if (b[7]) h = h + 7'd12;
        return h24 ? dec_field(b, bin) : h;
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] year);
        logic [6:0] d;
        case (mon)
            7'd4, 7'd6, 7'd9, 7'd11: d = 7'd30;
            7'd2:                    d = (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
            default:                 d = 7'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tod_sequencer.sv
module tod_sequencer
    import tod_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8,
    parameter int BUSY_TICKS    = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic freeze,
    output logic uip,
    output logic step,
    output logic done
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST    = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] LEAD_AT = CW'(TICKS_PER_SEC - LEAD_TICKS);
    localparam logic [CW-1:0] BUSY_AT = CW'(BUSY_TICKS);

    typedef struct packed {
        phase_t        phase;
        logic [CW-1:0] pre;
    } seq_t;

    seq_t          s_d, s_q;
    logic [CW-1:0] nxt_d;

    always_comb begin
        s_d   = s_q;
        step  = 1'b0;
        done  = 1'b0;
        nxt_d = (s_q.pre == LAST) ? '0 : s_q.pre + 1'b1;
        if (freeze) begin
            s_d.pre   = '0;
            s_d.phase = PH_IDLE;
        end else if (ref_tick) begin
            s_d.pre = nxt_d;
            case (s_q.phase)
                PH_IDLE: if (nxt_d == LEAD_AT) s_d.phase = PH_LEAD;
                PH_LEAD: if (nxt_d == '0) begin
                    s_d.phase = PH_BUSY;
                    step      = 1'b1;
                end
                PH_BUSY: if (nxt_d == BUSY_AT) begin
                    s_d.phase = PH_IDLE;
                    done      = 1'b1;
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.pre   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign uip = (s_q.phase != PH_IDLE);

    // R3: the flag drops only when an update ends or the counter is frozen
    a_r3_uip_fall_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> $past(done || freeze));
    // R3: fields change only inside the window
    a_r3_step_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> uip);
    // R5: freeze pulls the flag low
    a_r5_freeze_clears_uip: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> !uip);

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [NFIELD-1:0] wr_mask,
    input  tod_time_t         wr_val,
    output tod_time_t         tm
);
    tod_time_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (step) begin
            if (t_q.sec >= 7'd59) begin
                t_d.sec = 7'd0;
                if (t_q.min >= 7'd59) begin
                    t_d.min = 7'd0;
                    if (t_q.hour >= 7'd23) begin
                        t_d.hour = 7'd0;
                        t_d.dow  = (t_q.dow >= 7'd7) ? 7'd1 : t_q.dow + 7'd1;
                        if (t_q.dom >= month_days(t_q.mon, t_q.year)) begin
                            t_d.dom = 7'd1;
                            if (t_q.mon >= 7'd12) begin
                                t_d.mon  = 7'd1;
                                t_d.year = (t_q.year >= 7'd99) ? 7'd0 : t_q.year + 7'd1;
                            end else begin
                                t_d.mon = t_q.mon + 7'd1;
                            end
                        end else begin
                            t_d.dom = t_q.dom + 7'd1;
                        end
                    end else begin
                        t_d.hour = t_q.hour + 7'd1;
                    end
                end else begin
                    t_d.min = t_q.min + 7'd1;
                end
            end else begin
                t_d.sec = t_q.sec + 7'd1;
            end
        end
        if (wr_mask[0]) t_d.sec  = wr_val.sec;
        if (wr_mask[1]) t_d.min  = wr_val.min;
        if (wr_mask[2]) t_d.hour = wr_val.hour;
        if (wr_mask[3]) t_d.dow  = wr_val.dow;
        if (wr_mask[4]) t_d.dom  = wr_val.dom;
        if (wr_mask[5]) t_d.mon  = wr_val.mon;
        if (wr_mask[6]) t_d.year = wr_val.year;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '{sec: 7'd0, min: 7'd0, hour: 7'd0, dow: 7'd1,
                     dom: 7'd1, mon: 7'd1, year: 7'd0};
        end else begin
            t_q <= t_d;
        end
    end

    assign tm = t_q;

    // R2: with no advance and no write the time holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && wr_mask == '0) |=> $stable(t_q));
    // R2: seconds step by exactly one below the minute boundary
    a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wr_mask == '0 && t_q.sec < 7'd59) |=> (t_q.sec == $past(t_q.sec) + 7'd1));

endmodule

// File: rtl/tod_readmux.sv
module tod_readmux
    import tod_pkg::*;
(
    input  logic [3:0] rd_addr,
    input  tod_time_t  tm,
    input  logic [6:0] alm_sec,
    input  logic [6:0] alm_min,
    input  logic [6:0] alm_hour,
    input  logic [7:0] ctl,
    input  logic       af,
    input  logic       uf,
    input  logic       irq,
    input  logic       uip,
    output logic [7:0] rd_data
);
    logic bin, h24;
    assign bin = ctl[C_BIN];
    assign h24 = ctl[C_H24];

    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = enc_field(tm.sec, bin);
            A_ASEC:  rd_data = enc_field(alm_sec, bin);
            A_MIN:   rd_data = enc_field(tm.min, bin);
            A_AMIN:  rd_data = enc_field(alm_min, bin);
            A_HOUR:  rd_data = enc_hour(tm.hour, bin, h24);
            A_AHOUR: rd_data = enc_hour(alm_hour, bin, h24);
            A_DOW:   rd_data = enc_field(tm.dow, bin);
            A_DOM:   rd_data = enc_field(tm.dom, bin);
            A_MON:   rd_data = enc_field(tm.mon, bin);
            A_YEAR:  rd_data = enc_field(tm.year, bin);
            A_STAT:  rd_data = {uip, 7'd0};
            A_CTRL:  rd_data = ctl;
            A_FLAG:  rd_data = {irq, 1'b0, af, uf, 4'd0};
            default: rd_data = 8'd0;
        endcase
    end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8,
    parameter int BUSY_TICKS    = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       uip,
    output logic       irq
);
    typedef struct packed {
        logic [7:0] ctl;
        logic [6:0] asec;
        logic [6:0] amin;
        logic [6:0] ahour;
        logic       af;
        logic       uf;
    } regs_t;

    regs_t             r_d, r_q;
    logic              seq_step, seq_done;
    logic [NFIELD-1:0] wr_mask;
    tod_time_t         wr_val, tm;
    logic              bin, h24, match, clr;

    assign bin = r_q.ctl[C_BIN];
    assign h24 = r_q.ctl[C_H24];

    tod_sequencer #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .LEAD_TICKS   (LEAD_TICKS),
        .BUSY_TICKS   (BUSY_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_tick(ref_tick),
        .freeze  (r_q.ctl[C_FREEZE]),
        .uip     (uip),
        .step    (seq_step),
        .done    (seq_done)
    );

    always_comb begin
        wr_val.sec  = dec_field(wr_data, bin);
        wr_val.min  = dec_field(wr_data, bin);
        wr_val.hour = dec_hour(wr_data, bin, h24);
        wr_val.dow  = dec_field(wr_data, bin);
        wr_val.dom  = dec_field(wr_data, bin);
        wr_val.mon  = dec_field(wr_data, bin);
        wr_val.year = dec_field(wr_data, bin);
        wr_mask[0]  = wr_en && (wr_addr == A_SEC);
        wr_mask[1]  = wr_en && (wr_addr == A_MIN);
        wr_mask[2]  = wr_en && (wr_addr == A_HOUR);
        wr_mask[3]  = wr_en && (wr_addr == A_DOW);
        wr_mask[4]  = wr_en && (wr_addr == A_DOM);
        wr_mask[5]  = wr_en && (wr_addr == A_MON);
        wr_mask[6]  = wr_en && (wr_addr == A_YEAR);
    end

    tod_calendar u_cal (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (seq_step),
        .wr_mask(wr_mask),
        .wr_val (wr_val),
        .tm     (tm)
    );

    assign match = (tm.sec == r_q.asec) && (tm.min == r_q.amin) && (tm.hour == r_q.ahour);
    assign clr   = rd_en && (rd_addr == A_FLAG);

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.af = 1'b0;
            r_d.uf = 1'b0;
        end
        if (seq_done) begin
            r_d.uf = 1'b1;
            if (match) r_d.af = 1'b1;
        end
        if (wr_en) begin
            case (wr_addr)
                A_ASEC:  r_d.asec  = dec_field(wr_data, bin);
                A_AMIN:  r_d.amin  = dec_field(wr_data, bin);
                A_AHOUR: r_d.ahour = dec_hour(wr_data, bin, h24);
                A_CTRL:  r_d.ctl   = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{ctl: 8'h02, asec: 7'd0, amin: 7'd0, ahour: 7'd0, af: 1'b0, uf: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign irq = (r_q.af && r_q.ctl[C_AEN]) || (r_q.uf && r_q.ctl[C_UEN]);

    tod_readmux u_rd (
        .rd_addr (rd_addr),
        .tm      (tm),
        .alm_sec (r_q.asec),
        .alm_min (r_q.amin),
        .alm_hour(r_q.ahour),
        .ctl     (r_q.ctl),
        .af      (r_q.af),
        .uf      (r_q.uf),
        .irq     (irq),
        .uip     (uip),
        .rd_data (rd_data)
    );

    // R8 and R10: an update end always leaves the update flag set, even against a clear
    a_r8_uf_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> r_q.uf);
    // R8: the alarm flag rises only at the end of an update
    a_r8_af_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.af) |-> $past(seq_done));
    // R10: a clearing read with no event empties both flags
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !seq_done) |=> (!r_q.af && !r_q.uf));

endmodule

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;
    localparam int TPS  = 16;
    localparam int LEAD = 3;
    localparam int BUSY = 4;
    localparam int SEC_CYC = 2 * TPS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;
    logic       uip, irq;
    logic       tick_en = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    tod_clock #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD), .BUSY_TICKS(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .uip(uip), .irq(irq)
    );

    always @(negedge clk) ref_tick = tick_en ? ~ref_tick : 1'b0;

    // ---------------- reference model ----------------
    int m_s, m_m, m_h, m_dow, m_dom, m_mon, m_yr;
    int m_as, m_am, m_ah;
    int m_ctl, m_cnt, m_phase;
    bit m_af, m_uf;

    function automatic int enc(int v, bit b);
        return b ? v : (v / 10) * 16 + v % 10;
    endfunction
    function automatic int dec(int x, bit b);
        return b ? (x & 127) : (x >> 4) * 10 + (x & 15);
    endfunction
    function automatic int henc(int h, bit b, bit t);
        int h12;
        if (t) return enc(h, b);
        h12 = h % 12;
        if (h12 == 0) h12 = 12;
        return ((h >= 12) ? 128 : 0) + enc(h12, b);
    endfunction
    function automatic int hdec(int x, bit b, bit t);
        int h12;
        if (t) return dec(x, b);
        h12 = dec(x & 127, b);
        if (h12 == 12) h12 = 0;
        return h12 + (((x & 128) != 0) ? 12 : 0);
    endfunction
    function automatic int mdays(int mo, int y);
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        return 31;
    endfunction
    function automatic bit m_irq();
        return (m_af && m_ctl[5]) || (m_uf && m_ctl[4]);
    endfunction
    function automatic int m_read(int a);
        bit b, t;
        b = m_ctl[2];
        t = m_ctl[1];
        case (a)
            0: return enc(m_s, b);
            1: return enc(m_as, b);
            2: return enc(m_m, b);
            3: return enc(m_am, b);
            4: return henc(m_h, b, t);
            5: return henc(m_ah, b, t);
            6: return enc(m_dow, b);
            7: return enc(m_dom, b);
            8: return enc(m_mon, b);
            9: return enc(m_yr, b);
            10: return (m_phase != 0) ? 128 : 0;
            11: return m_ctl;
            12: return (m_irq() ? 128 : 0) + (m_af ? 32 : 0) + (m_uf ? 16 : 0);
            default: return 0;
        endcase
    endfunction

    task automatic m_advance();
        m_s++;
        if (m_s < 60) return;
        m_s = 0; m_m++;
        if (m_m < 60) return;
        m_m = 0; m_h++;
        if (m_h < 24) return;
        m_h = 0;
        m_dow = (m_dow >= 7) ? 1 : m_dow + 1;
        if (m_dom < mdays(m_mon, m_yr)) begin m_dom++; return; end
        m_dom = 1;
        if (m_mon < 12) begin m_mon++; return; end
        m_mon = 1;
        m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s = 0; m_m = 0; m_h = 0; m_dow = 1; m_dom = 1; m_mon = 1; m_yr = 0;
            m_as = 0; m_am = 0; m_ah = 0; m_ctl = 8'h02; m_cnt = 0; m_phase = 0;
            m_af = 0; m_uf = 0;
        end else begin
            bit adv, dn, hit, b, t;
            adv = 0; dn = 0;
            b = m_ctl[2]; t = m_ctl[1];
            hit = (m_s == m_as) && (m_m == m_am) && (m_h == m_ah);
            if (m_ctl[7]) begin
                m_cnt = 0; m_phase = 0;
            end else if (ref_tick) begin
                m_cnt = (m_cnt + 1) % TPS;
                if (m_phase == 0 && m_cnt == TPS - LEAD) m_phase = 1;
                else if (m_phase == 1 && m_cnt == 0) begin m_phase = 2; adv = 1; end
                else if (m_phase == 2 && m_cnt == BUSY) begin m_phase = 0; dn = 1; end
            end
            if (rd_en && rd_addr == 4'd12) begin m_af = 0; m_uf = 0; end
            if (dn) begin m_uf = 1; if (hit) m_af = 1; end
            if (adv) m_advance();
            if (wr_en) begin
                case (wr_addr)
                    0: m_s   = dec(wr_data, b);
                    1: m_as  = dec(wr_data, b);
                    2: m_m   = dec(wr_data, b);
                    3: m_am  = dec(wr_data, b);
                    4: m_h   = hdec(wr_data, b, t);
                    5: m_ah  = hdec(wr_data, b, t);
                    6: m_dow = dec(wr_data, b);
                    7: m_dom = dec(wr_data, b);
                    8: m_mon = dec(wr_data, b);
                    9: m_yr  = dec(wr_data, b);
                    11: m_ctl = wr_data;
                    default: ;
                endcase
            end
            #5;
            chk("R3 uip", uip, (m_phase != 0));
            chk("R9 irq", irq, m_irq());
            chk("R1 rd_data", rd_data, m_read(rd_addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask
    task automatic clr_flags();
        @(negedge clk);
        rd_en = 1; rd_addr = 4'd12;
        @(negedge clk);
        rd_en = 0;
    endtask
    task automatic rd(int a, output int v);
        @(negedge clk);
        rd_addr = 4'(a);
        #1 v = rd_data;
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_addr = 4'(i % 13);
        end
    endtask
    task automatic set_time(int h, int mi, int s);
        wr(4, h); wr(2, mi); wr(0, s);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        rd(0, v);  chk("R11 sec", v, 8'h00);
        rd(4, v);  chk("R11 hour", v, 8'h00);
        rd(6, v);  chk("R11 dow", v, 8'h01);
        rd(8, v);  chk("R11 month", v, 8'h01);
        rd(11, v); chk("R11 ctrl", v, 8'h02);
        rd(12, v); chk("R11 flags", v, 8'h00);
        chk("R11 uip", uip, 0);
        tick_en = 1;
        idle(3 * SEC_CYC + 16);
        rd(0, v); chk("R2 three seconds", v, 8'h03);

        // R4 non-leap February end, R2 full carry, R5 freeze
        wr(11, 8'h82);
        set_time(8'h23, 8'h59, 8'h58);
        wr(6, 8'h07); wr(7, 8'h28); wr(8, 8'h02); wr(9, 8'h03);
        idle(2 * SEC_CYC);
        rd(0, v);  chk("R5 frozen sec", v, 8'h58);
        chk("R5 uip low when frozen", uip, 0);
        wr(11, 8'h02);
        idle(3 * SEC_CYC + 16);
        rd(0, v);  chk("R2 sec after carry", v, 8'h01);
        rd(4, v);  chk("R2 hour wrap", v, 8'h00);
        rd(6, v);  chk("R2 dow wrap", v, 8'h01);
        rd(7, v);  chk("R4 day after Feb 28", v, 8'h01);
        rd(8, v);  chk("R4 month after Feb", v, 8'h03);

        // R4 leap year
        wr(11, 8'h82);
        set_time(8'h23, 8'h59, 8'h59);
        wr(7, 8'h28); wr(8, 8'h02); wr(9, 8'h04);
        wr(11, 8'h02);
        idle(SEC_CYC + 16);
        rd(7, v); chk("R4 leap Feb 29", v, 8'h29);
        wr(11, 8'h82);
        set_time(8'h23, 8'h59, 8'h59);
        wr(11, 8'h02);
        idle(SEC_CYC + 16);
        rd(7, v); chk("R4 leap end day", v, 8'h01);
        rd(8, v); chk("R4 leap end month", v, 8'h03);

        // R2 year wrap
        wr(11, 8'h82);
        set_time(8'h23, 8'h59, 8'h59);
        wr(7, 8'h31); wr(8, 8'h12); wr(9, 8'h99);
        wr(11, 8'h02);
        idle(SEC_CYC + 16);
        rd(9, v); chk("R2 year wrap", v, 8'h00);
        rd(8, v); chk("R2 month wrap", v, 8'h01);

        // R6 binary vs BCD
        wr(11, 8'h86);
        wr(0, 45);
        rd(0, v); chk("R6 binary read", v, 45);
        wr(11, 8'h82);
        rd(0, v); chk("R6 bcd read", v, 8'h45);

        // R7 12-hour mode
        wr(11, 8'h80);
        set_time(8'h11, 8'h59, 8'h59);
        rd(4, v); chk("R7 11 AM", v, 8'h11);
        wr(11, 8'h00);
        idle(SEC_CYC + 16);
        rd(4, v); chk("R7 noon PM", v, 8'h92);
        wr(11, 8'h80);
        set_time(8'h91, 8'h59, 8'h59);
        wr(11, 8'h00);
        idle(SEC_CYC + 16);
        rd(4, v); chk("R7 midnight AM", v, 8'h12);
        wr(11, 8'h82);
        rd(4, v); chk("R7 24h view", v, 8'h00);

        // R8 R9 R10 alarm and flags
        set_time(8'h10, 8'h20, 8'h30);
        wr(5, 8'h10); wr(3, 8'h20); wr(1, 8'h32);
        clr_flags();
        wr(11, 8'h22);
        idle(SEC_CYC + 16);
        rd(12, v); chk("R8 update flag only", v, 8'h10);
        chk("R9 irq off without alarm", irq, 0);
        clr_flags();
        idle(SEC_CYC - 4);
        rd(12, v); chk("R8 alarm flag", v, 8'hB0);
        chk("R9 irq on alarm", irq, 1);
        clr_flags();
        rd(12, v); chk("R10 read clears", v, 8'h00);
        wr(12, 8'hFF);
        rd(12, v); chk("R10 flag write ignored", v, 8'h00);
        wr(11, 8'h92);
        wr(10, 8'hFF);
        rd(10, v); chk("R10 status write ignored", v, 8'h00);
        wr(11, 8'h12);
        idle(SEC_CYC + 16);
        chk("R9 irq on update", irq, 1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule